// File: doc/BRIEF.md
# Multi-vector group accumulate sequencer

This block carries out one widened dot-product accumulate across a small set of accumulator rows. It holds three storage arrays of its own: a file of 32 vector registers, an accumulator array whose row count equals the vector length in bytes, and four 32-bit select registers. A start pulse supplies an operation: a group count (two or four), a base index for the first source, an index for the shared second source, a select-register choice, a 3-bit offset and an element-size choice.

For each group, the sequencer reads one first-source register, the shared second-source register and one accumulator row. It forms a four-way signed dot product in every element and adds it to the old element value, which wraps at the element width. It then writes the row back. The first row is the chosen select value plus the offset, taken modulo the stride, where the stride is the row count divided by the group count. Each later group adds the stride to the row index, and each later group takes the next first-source register, wrapping at 32.

A host side loads the arrays and reads accumulator rows while the block is idle. Each group takes a read, a compute and a write cycle. A one-cycle done pulse closes the operation.

Top module: `mvgrp_acc_seq`

## Requirements
- R1: After reset, busy and done are low and every accumulator row reads as zero.
- R2: A start pulse seen while idle raises busy on the next cycle. Done is high for exactly one cycle, 3*G+1 cycles after the edge that sampled start, where G is 2 when grp4 is 0 and 4 when grp4 is 1.
- R3: With size64 at 0, each 32-bit element e of the written row equals the old element plus the sum, over i = 0..3, of the signed byte 4e+i of the first source times the signed byte 4e+i of the second source, modulo 2^32. Byte k occupies bits 8k+7:8k.
- R4: With size64 at 1, each 64-bit element e equals the old element plus the sum, over i = 0..3, of products of signed 16-bit halfword 4e+i of the two sources, modulo 2^64. Halfword k occupies bits 16k+15:16k.
- R5: The first group writes row (S + offset) mod (ROWS/G), where S is the 32-bit select value and the sum wraps at 32 bits.
- R6: Group r writes the first row plus r*(ROWS/G). Rows not addressed by any group keep their contents.
- R7: Group r uses first-source register (zn + r) mod 32.
- R8: Every group uses the same second-source register, given by the 4-bit zm index (registers 0 to 15).
- R9: The select value S is the contents of the select register numbered by the 2-bit sel_idx input at the start edge.
- R10: While busy, start pulses and all host writes to the vector, accumulator and select arrays have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, sampled while idle |
| grp4_i | input | 1 | 1: four groups, 0: two groups |
| size64_i | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| zn_i | input | 5 | Base first-source register index |
| zm_i | input | 4 | Second-source register index |
| sel_idx_i | input | 2 | Select-register choice |
| offs_i | input | 3 | Row offset |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| vreg_we_i | input | 1 | Host vector register write |
| vreg_waddr_i | input | 5 | Host vector register index |
| vreg_wdata_i | input | VLEN_BYTES*8 | Host vector register data |
| acc_we_i | input | 1 | Host accumulator row write |
| acc_waddr_i | input | log2(VLEN_BYTES) | Host accumulator row index for writes |
| acc_wdata_i | input | VLEN_BYTES*8 | Host accumulator row data |
| acc_raddr_i | input | log2(VLEN_BYTES) | Accumulator row index for reads |
| acc_rdata_o | output | VLEN_BYTES*8 | Accumulator row contents (combinational) |
| sel_we_i | input | 1 | Host select register write |
| sel_waddr_i | input | 2 | Host select register index |
| sel_wdata_i | input | 32 | Host select register data |

## Verification
If the row-index state is wrong, a row outside the expected set changes, or an expected row keeps its old value. This shows on the read port as soon as the done pulse of that operation appears. A faulty group counter or state register moves the done pulse away from cycle 3*G+1, or makes it longer than one cycle, on the very first operation. A bad source-index or lane computation corrupts the written elements. Every accumulator row is compared with an independent model after each operation, so any such fault is caught before the next start.

// File: rtl/mvgrp_pkg.sv
`timescale 1ns/1ps
package mvgrp_pkg;

    localparam int NUM_VREGS   = 32;
    localparam int VREG_IDX_W  = $clog2(NUM_VREGS);
    localparam int ZM_IDX_W    = VREG_IDX_W - 1;
    localparam int NUM_SELS    = 4;
    localparam int SEL_IDX_W   = $clog2(NUM_SELS);
    localparam int SEL_W       = 32;
    localparam int OFFS_W      = 3;
    localparam int MAX_GROUPS  = 4;
    localparam int GRP_IDX_W   = $clog2(MAX_GROUPS);
    localparam int WAYS        = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COMPUTE,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic                  grp4;
        logic                  size64;
        logic [VREG_IDX_W-1:0] zn;
        logic [ZM_IDX_W-1:0]   zm;
        logic [SEL_IDX_W-1:0]  sel;
        logic [OFFS_W-1:0]     offs;
    } op_t;

    // signed 8x8 product, sign-extended to 32 bits
    function automatic logic [31:0] smul8(input logic [7:0] x, input logic [7:0] y);
        logic signed [15:0] xs;
        logic signed [15:0] ys;
        logic signed [15:0] p;
        xs = {{8{x[7]}}, x};
        ys = {{8{y[7]}}, y};
        p  = xs * ys;
        return {{16{p[15]}}, p};
    endfunction

    // signed 16x16 product, sign-extended to 64 bits
    function automatic logic [63:0] smul16(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] xs;
        logic signed [31:0] ys;
        logic signed [31:0] p;
        xs = {{16{x[15]}}, x};
        ys = {{16{y[15]}}, y};
        p  = xs * ys;
        return {{32{p[31]}}, p};
    endfunction

endpackage

// File: rtl/mvgrp_lane_dot.sv
`timescale 1ns/1ps
// Row-wide four-way signed dot-product accumulate, both element sizes.
module mvgrp_lane_dot
    import mvgrp_pkg::*;
#(
    parameter int VL_BITS = 128
) (
    input  logic [VL_BITS-1:0] src1_i,
    input  logic [VL_BITS-1:0] src2_i,
    input  logic [VL_BITS-1:0] acc_i,
    input  logic               size64_i,
    output logic [VL_BITS-1:0] res_o
);

    localparam int N32 = VL_BITS / 32;
    localparam int N64 = VL_BITS / 64;

    logic [VL_BITS-1:0] res32;
    logic [VL_BITS-1:0] res64;

    for (genvar e = 0; e < N32; e++) begin : g_e32
        logic [31:0] sum_d;
        always_comb begin
            sum_d = acc_i[e*32 +: 32];
            for (int i = 0; i < WAYS; i++) begin
                sum_d = sum_d + smul8(src1_i[(WAYS*e+i)*8 +: 8],
                                      src2_i[(WAYS*e+i)*8 +: 8]);
            end
        end
        assign res32[e*32 +: 32] = sum_d;
    end

    for (genvar e = 0; e < N64; e++) begin : g_e64
        logic [63:0] sum_d;
        always_comb begin
            sum_d = acc_i[e*64 +: 64];
            for (int i = 0; i < WAYS; i++) begin
                sum_d = sum_d + smul16(src1_i[(WAYS*e+i)*16 +: 16],
                                       src2_i[(WAYS*e+i)*16 +: 16]);
            end
        end
        assign res64[e*64 +: 64] = sum_d;
    end

    assign res_o = size64_i ? res64 : res32;

endmodule

// File: rtl/mvgrp_row_map.sv
`timescale 1ns/1ps
// Maps select value, offset and group number to an accumulator row.
module mvgrp_row_map
    import mvgrp_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic [SEL_W-1:0]         sel_val_i,
    input  logic [OFFS_W-1:0]        offs_i,
    input  logic                     grp4_i,
    input  logic [GRP_IDX_W-1:0]     grp_i,
    output logic [$clog2(ROWS)-1:0]  row_o
);

    localparam int ROW_W   = $clog2(ROWS);
    localparam int STR_TWO = ROWS / 2;
    localparam int STR_FOUR = ROWS / 4;

    logic [SEL_W-1:0] base_sum;
    logic [ROW_W-1:0] stride;
    logic [ROW_W-1:0] first_row;

    always_comb begin
        base_sum = sel_val_i + SEL_W'(offs_i);
        if (grp4_i) begin
            stride    = ROW_W'(STR_FOUR);
            first_row = ROW_W'(base_sum % SEL_W'(STR_FOUR));
        end else begin
            stride    = ROW_W'(STR_TWO);
            first_row = ROW_W'(base_sum % SEL_W'(STR_TWO));
        end
        row_o = first_row + ROW_W'(grp_i) * stride;
    end

endmodule

// File: rtl/mvgrp_ctrl.sv
`timescale 1ns/1ps
// Group sequencer: idle, then read/compute/write per group, then done.
module mvgrp_ctrl
    import mvgrp_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  op_t                  op_i,
    output seq_state_e           state_o,
    output logic [GRP_IDX_W-1:0] grp_o,
    output op_t                  op_o,
    output logic                 busy_o,
    output logic                 done_o
);

    typedef struct packed {
        seq_state_e           st;
        logic [GRP_IDX_W-1:0] grp;
        op_t                  op;
    } ctrl_t;

    ctrl_t c_d;
    ctrl_t c_q;
    logic  last_grp;

    always_comb begin
        c_d      = c_q;
        last_grp = (c_q.grp == (c_q.op.grp4 ? GRP_IDX_W'(3) : GRP_IDX_W'(1)));
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st  = ST_READ;
                    c_d.grp = '0;
                    c_d.op  = op_i;
                end
            end
            ST_READ:    c_d.st = ST_COMPUTE;
            ST_COMPUTE: c_d.st = ST_WRITE;
            ST_WRITE: begin
                if (last_grp) begin
                    c_d.st = ST_DONE;
                end else begin
                    c_d.st  = ST_READ;
                    c_d.grp = c_q.grp + GRP_IDX_W'(1);
                end
            end
            ST_DONE:    c_d.st = ST_IDLE;
            default:    c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q <= '{st: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign state_o = c_q.st;
    assign grp_o   = c_q.grp;
    assign op_o    = c_q.op;
    assign busy_o  = (c_q.st != ST_IDLE);
    assign done_o  = (c_q.st == ST_DONE);

endmodule

// File: rtl/mvgrp_acc_seq.sv
`timescale 1ns/1ps
module mvgrp_acc_seq
    import mvgrp_pkg::*;
#(
    parameter  int VLEN_BYTES = 16,
    localparam int VL_BITS    = VLEN_BYTES * 8,
    localparam int ROWS       = VLEN_BYTES,
    localparam int ROW_W      = $clog2(ROWS)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic                  grp4_i,
    input  logic                  size64_i,
    input  logic [4:0]            zn_i,
    input  logic [3:0]            zm_i,
    input  logic [1:0]            sel_idx_i,
    input  logic [2:0]            offs_i,
    output logic                  busy_o,
    output logic                  done_o,
    input  logic                  vreg_we_i,
    input  logic [4:0]            vreg_waddr_i,
    input  logic [VL_BITS-1:0]    vreg_wdata_i,
    input  logic                  acc_we_i,
    input  logic [ROW_W-1:0]      acc_waddr_i,
    input  logic [VL_BITS-1:0]    acc_wdata_i,
    input  logic [ROW_W-1:0]      acc_raddr_i,
    output logic [VL_BITS-1:0]    acc_rdata_o,
    input  logic                  sel_we_i,
    input  logic [1:0]            sel_waddr_i,
    input  logic [31:0]           sel_wdata_i
);

    typedef struct packed {
        logic [VL_BITS-1:0] src1;
        logic [VL_BITS-1:0] src2;
        logic [VL_BITS-1:0] accv;
        logic [VL_BITS-1:0] res;
    } dp_t;

    logic [VL_BITS-1:0]    vreg_q [NUM_VREGS];
    logic [VL_BITS-1:0]    acc_q  [ROWS];
    logic [SEL_W-1:0]      sel_q  [NUM_SELS];

    op_t                   op_in;
    op_t                   op_q;
    seq_state_e            state;
    logic [GRP_IDX_W-1:0]  grp;
    logic                  busy;
    logic [ROW_W-1:0]      row_idx;
    logic [VREG_IDX_W-1:0] src_idx;
    logic [VL_BITS-1:0]    lane_res;
    logic                  seq_acc_we;
    logic                  host_ok;
    logic                  cur_grp4;
    dp_t                   dp_d;
    dp_t                   dp_q;

    assign op_in = '{grp4: grp4_i, size64: size64_i, zn: zn_i, zm: zm_i,
                     sel: sel_idx_i, offs: offs_i};

    mvgrp_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .op_i    (op_in),
        .state_o (state),
        .grp_o   (grp),
        .op_o    (op_q),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    mvgrp_row_map #(.ROWS(ROWS)) u_row_map (
        .sel_val_i (sel_q[op_q.sel]),
        .offs_i    (op_q.offs),
        .grp4_i    (op_q.grp4),
        .grp_i     (grp),
        .row_o     (row_idx)
    );

    mvgrp_lane_dot #(.VL_BITS(VL_BITS)) u_lane (
        .src1_i   (dp_q.src1),
        .src2_i   (dp_q.src2),
        .acc_i    (dp_q.accv),
        .size64_i (op_q.size64),
        .res_o    (lane_res)
    );

    assign src_idx    = op_q.zn + VREG_IDX_W'(grp);
    assign seq_acc_we = (state == ST_WRITE);
    assign host_ok    = !busy;
    assign cur_grp4   = op_q.grp4;

    always_comb begin
        dp_d = dp_q;
        unique case (state)
            ST_READ: begin
                dp_d.src1 = vreg_q[src_idx];
                dp_d.src2 = vreg_q[{1'b0, op_q.zm}];
                dp_d.accv = acc_q[row_idx];
            end
            ST_COMPUTE: dp_d.res = lane_res;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_VREGS; i++) vreg_q[i] <= '0;
            for (int i = 0; i < ROWS; i++)      acc_q[i]  <= '0;
            for (int i = 0; i < NUM_SELS; i++)  sel_q[i]  <= '0;
        end else begin
            if (host_ok && vreg_we_i) vreg_q[vreg_waddr_i] <= vreg_wdata_i;
            if (host_ok && sel_we_i)  sel_q[sel_waddr_i]   <= sel_wdata_i;
            if (host_ok && acc_we_i)  acc_q[acc_waddr_i]   <= acc_wdata_i;
            if (seq_acc_we)           acc_q[row_idx]       <= dp_q.res;
        end
    end

    assign acc_rdata_o = acc_q[acc_raddr_i];
    assign busy_o      = busy;

endmodule

// File: rtl/mvgrp_checker.sv
`timescale 1ns/1ps
module mvgrp_checker #(
    parameter  int VLEN_BYTES = 16,
    localparam int ROWS       = VLEN_BYTES,
    localparam int ROW_W      = $clog2(ROWS)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_i,
    input logic             done_i,
    input logic             seq_we_i,
    input logic [ROW_W-1:0] seq_row_i,
    input logic             grp4_i
);

    logic [2:0]       wr_cnt;
    logic [ROW_W-1:0] last_row;
    logic [ROW_W-1:0] stride;

    assign stride = grp4_i ? ROW_W'(ROWS / 4) : ROW_W'(ROWS / 2);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wr_cnt   <= '0;
            last_row <= '0;
        end else begin
            if (start_i && !busy_i) wr_cnt <= '0;
            else if (seq_we_i)      wr_cnt <= wr_cnt + 3'd1;
            if (seq_we_i) last_row <= seq_row_i;
        end
    end

    a_r2_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i) |=> busy_i);

    a_r2_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> $past(seq_we_i));

    a_r2_write_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> (wr_cnt == (grp4_i ? 3'd4 : 3'd2)));

    a_r5_first_row_in_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_we_i && wr_cnt == 3'd0) |-> (seq_row_i < stride));

    a_r6_stride_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_we_i && wr_cnt != 3'd0) |-> (seq_row_i == ROW_W'(last_row + stride)));

    a_r10_op_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i)) |-> $stable(grp4_i));

endmodule

bind mvgrp_acc_seq mvgrp_checker #(.VLEN_BYTES(VLEN_BYTES)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_i    (busy_o),
    .done_i    (done_o),
    .seq_we_i  (seq_acc_we),
    .seq_row_i (row_idx),
    .grp4_i    (cur_grp4)
);

// File: tb/tb_mvgrp_acc_seq.sv
`timescale 1ns/1ps
module tb_mvgrp_acc_seq;

    localparam int VLB    = 16;
    localparam int VLBITS = VLB * 8;
    localparam int ROWS   = VLB;
    localparam int RW     = $clog2(ROWS);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0, grp4 = 1'b0, size64 = 1'b0;
    logic [4:0]        zn = '0;
    logic [3:0]        zm = '0;
    logic [1:0]        sel_idx = '0;
    logic [2:0]        offs = '0;
    logic              busy, done;
    logic              vreg_we = 1'b0;
    logic [4:0]        vreg_waddr = '0;
    logic [VLBITS-1:0] vreg_wdata = '0;
    logic              acc_we = 1'b0;
    logic [RW-1:0]     acc_waddr = '0;
    logic [VLBITS-1:0] acc_wdata = '0;
    logic [RW-1:0]     acc_raddr = '0;
    logic [VLBITS-1:0] acc_rdata;
    logic              sel_we = 1'b0;
    logic [1:0]        sel_waddr = '0;
    logic [31:0]       sel_wdata = '0;

    mvgrp_acc_seq #(.VLEN_BYTES(VLB)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .grp4_i(grp4),
        .size64_i(size64), .zn_i(zn), .zm_i(zm), .sel_idx_i(sel_idx),
        .offs_i(offs), .busy_o(busy), .done_o(done),
        .vreg_we_i(vreg_we), .vreg_waddr_i(vreg_waddr), .vreg_wdata_i(vreg_wdata),
        .acc_we_i(acc_we), .acc_waddr_i(acc_waddr), .acc_wdata_i(acc_wdata),
        .acc_raddr_i(acc_raddr), .acc_rdata_o(acc_rdata),
        .sel_we_i(sel_we), .sel_waddr_i(sel_waddr), .sel_wdata_i(sel_wdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [VLBITS-1:0] m_v   [32];
    logic [VLBITS-1:0] m_acc [ROWS];
    logic [31:0]       m_sel [4];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VLBITS-1:0] act, input logic [VLBITS-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [VLBITS-1:0] mkpat(input int k);
        logic [VLBITS-1:0] p;
        for (int j = 0; j < VLB; j++) p[j*8 +: 8] = 8'((k * 37 + j * 91 + (j * j) * 13) ^ (k << 3));
        return p;
    endfunction

    // independent model of the row update
    function automatic logic [VLBITS-1:0] dot_model(input logic [VLBITS-1:0] a,
            input logic [VLBITS-1:0] b, input logic [VLBITS-1:0] acc, input bit s64);
        logic [VLBITS-1:0] r;
        r = acc;
        if (!s64) begin
            for (int e = 0; e < VLBITS / 32; e++) begin
                longint tot;
                tot = longint'(acc[e*32 +: 32]);
                for (int i = 0; i < 4; i++) begin
                    int x, y;
                    x = int'($signed(a[(4*e+i)*8 +: 8]));
                    y = int'($signed(b[(4*e+i)*8 +: 8]));
                    tot = tot + longint'(x * y);
                end
                r[e*32 +: 32] = tot[31:0];
            end
        end else begin
            for (int e = 0; e < VLBITS / 64; e++) begin
                logic [63:0] tot;
                tot = acc[e*64 +: 64];
                for (int i = 0; i < 4; i++) begin
                    longint x, y;
                    x = longint'($signed(a[(4*e+i)*16 +: 16]));
                    y = longint'($signed(b[(4*e+i)*16 +: 16]));
                    tot = tot + 64'(x * y);
                end
                r[e*64 +: 64] = tot;
            end
        end
        return r;
    endfunction

    task automatic wr_vreg(input int idx, input logic [VLBITS-1:0] d);
        @(negedge clk); vreg_we = 1'b1; vreg_waddr = 5'(idx); vreg_wdata = d;
        @(negedge clk); vreg_we = 1'b0;
        m_v[idx] = d;
    endtask

    task automatic wr_acc(input int idx, input logic [VLBITS-1:0] d);
        @(negedge clk); acc_we = 1'b1; acc_waddr = RW'(idx); acc_wdata = d;
        @(negedge clk); acc_we = 1'b0;
        m_acc[idx] = d;
    endtask

    task automatic wr_sel(input int idx, input logic [31:0] d);
        @(negedge clk); sel_we = 1'b1; sel_waddr = 2'(idx); sel_wdata = d;
        @(negedge clk); sel_we = 1'b0;
        m_sel[idx] = d;
    endtask

    task automatic model_op(input bit g4, input bit s64, input int zn_v, input int zm_v,
                            input int sel_v, input int offs_v, output logic [ROWS-1:0] mask);
        int g, stride, row;
        logic [31:0] bsum;
        g      = g4 ? 4 : 2;
        stride = ROWS / g;
        bsum   = m_sel[sel_v] + 32'(offs_v);
        row    = int'(bsum % 32'(stride));
        mask   = '0;
        for (int r = 0; r < g; r++) begin
            m_acc[row] = dot_model(m_v[(zn_v + r) % 32], m_v[zm_v], m_acc[row], s64);
            mask[row]  = 1'b1;
            row        = row + stride;
        end
    endtask

    task automatic check_all(input string req, input logic [ROWS-1:0] mask);
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk); acc_raddr = RW'(r);
            #0.5;
            chk(acc_rdata === m_acc[r], mask[r] ? req : "R6",
                $sformatf("row %0d", r), acc_rdata, m_acc[r]);
        end
    endtask

    task automatic drive_op(input bit g4, input bit s64, input int zn_v, input int zm_v,
                            input int sel_v, input int offs_v);
        grp4 = g4; size64 = s64; zn = 5'(zn_v); zm = 4'(zm_v);
        sel_idx = 2'(sel_v); offs = 3'(offs_v);
    endtask

    // launch, check R2 timing, then compare all rows against the model
    task automatic run_op(input bit g4, input bit s64, input int zn_v, input int zm_v,
                          input int sel_v, input int offs_v, input string req);
        int k, g;
        logic [ROWS-1:0] mask;
        g = g4 ? 4 : 2;
        @(negedge clk); drive_op(g4, s64, zn_v, zm_v, sel_v, offs_v); start = 1'b1;
        @(negedge clk); start = 1'b0; k = 1;
        chk(busy === 1'b1, "R2", "busy after start", VLBITS'(busy), VLBITS'(1));
        while (!done && k < 200) begin @(negedge clk); k++; end
        chk(k == 3 * g + 1, "R2", "done latency", VLBITS'(k), VLBITS'(3 * g + 1));
        @(negedge clk);
        chk(done === 1'b0, "R2", "done width", VLBITS'(done), VLBITS'(0));
        model_op(g4, s64, zn_v, zm_v, sel_v, offs_v, mask);
        check_all(req, mask);
    endtask

    task automatic t_reset();
        chk(busy === 1'b0, "R1", "busy at reset", VLBITS'(busy), VLBITS'(0));
        chk(done === 1'b0, "R1", "done at reset", VLBITS'(done), VLBITS'(0));
        check_all("R1", '1);
    endtask

    task automatic t_basic32();
        wr_vreg(3, mkpat(3)); wr_vreg(4, mkpat(4)); wr_vreg(5, mkpat(5));
        wr_acc(2, mkpat(40)); wr_acc(10, mkpat(41));
        run_op(1'b0, 1'b0, 3, 5, 0, 2, "R3 R5");
    endtask

    task automatic t_overflow32();
        wr_vreg(6, {VLB{8'h80}}); wr_vreg(7, {VLB{8'h80}});
        wr_acc(0, {4{32'h7FFF_FFF0}}); wr_acc(8, {4{32'hFFFF_0000}});
        wr_sel(1, 32'd0);
        run_op(1'b0, 1'b0, 6, 7, 1, 0, "R3");
    endtask

    task automatic t_mode64();
        wr_vreg(8, mkpat(8)); wr_vreg(9, mkpat(9)); wr_vreg(10, mkpat(10));
        wr_vreg(11, {8{16'h8000}}); wr_vreg(12, mkpat(12));
        wr_sel(2, 32'd5);
        run_op(1'b1, 1'b1, 8, 9, 2, 1, "R4 R5");
    endtask

    task automatic t_wrap_src();
        wr_vreg(30, mkpat(30)); wr_vreg(31, mkpat(31));
        wr_vreg(0, mkpat(50)); wr_vreg(1, mkpat(51)); wr_vreg(15, mkpat(15));
        wr_sel(3, 32'hFFFF_FFFF);
        run_op(1'b1, 1'b0, 30, 15, 3, 3, "R7 R8 R5");
    endtask

    task automatic t_sel_pick();
        wr_sel(0, 32'd1); wr_sel(1, 32'd2); wr_sel(2, 32'd13); wr_sel(3, 32'd4);
        run_op(1'b0, 1'b0, 4, 3, 2, 7, "R9");
    endtask

    task automatic t_busy_ignore();
        int k;
        logic [ROWS-1:0] mask;
        wr_vreg(20, mkpat(20)); wr_vreg(21, mkpat(21)); wr_sel(3, 32'd1);
        @(negedge clk); drive_op(1'b0, 1'b0, 3, 5, 0, 0); start = 1'b1;
        @(negedge clk); start = 1'b0; k = 1;
        // while busy: new start, host writes to all three arrays
        drive_op(1'b1, 1'b1, 9, 9, 2, 5); start = 1'b1;
        acc_we = 1'b1; acc_waddr = RW'(5); acc_wdata = {VLB{8'h5A}};
        vreg_we = 1'b1; vreg_waddr = 5'd20; vreg_wdata = {VLB{8'hA5}};
        sel_we = 1'b1; sel_waddr = 2'd3; sel_wdata = 32'd6;
        @(negedge clk); k++;
        start = 1'b0; acc_we = 1'b0; vreg_we = 1'b0; sel_we = 1'b0;
        while (!done && k < 200) begin @(negedge clk); k++; end
        chk(k == 7, "R10", "latency with start while busy", VLBITS'(k), VLBITS'(7));
        @(negedge clk);
        model_op(1'b0, 1'b0, 3, 5, 0, 0, mask);
        check_all("R10", mask);
        // the ignored vreg and select writes must not be visible to a later op
        run_op(1'b0, 1'b0, 20, 4, 3, 0, "R10");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_v[i] = '0;
        for (int i = 0; i < ROWS; i++) m_acc[i] = '0;
        for (int i = 0; i < 4; i++) m_sel[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic32();
        t_overflow32();
        t_mode64();
        t_wrap_src();
        t_sel_pick();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule